// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block produces the two timer pending levels that a supervisor-capable core with hypervisor support needs. It stores a 64-bit compare value for the supervisor timer, a second 64-bit compare value for the guest (virtual supervisor) timer, and a 64-bit offset that is added to the shared time count to form the guest's view of time. Software reaches all three through a narrow register port with a 12-bit address and 32-bit data, so each 64-bit value is split into a low half and a high half at separate addresses.

Each cycle the block compares the free-running time count against the supervisor compare value, and the time count plus offset (wrapped to 64 bits) against the guest compare value. Both comparisons are unsigned, and each result is captured in a flop that drives a level-sensitive pending output. A pending level stays high for as long as its condition holds and falls once software moves the compare value above the time operand. Enables, delegation and trap entry live elsewhere in the core.

Top module: `stc_timer_cmp`

## Requirements
- R1: After reset both compare registers read all ones, the offset register reads zero, and both pending outputs are low.
- R2: Address 0x14D reads and writes bits 31:0 of the supervisor compare value; address 0x15D reads and writes bits 63:32 of it; a write to one half leaves the other half unchanged.
- R3: Address 0x24D reads and writes bits 31:0 of the guest compare value; address 0x25D reads and writes bits 63:32 of it; a write to one half leaves the other half unchanged.
- R4: Address 0x64A reads and writes bits 31:0 of the guest time offset; address 0x65A reads and writes bits 63:32 of it.
- R5: The supervisor pending output is high exactly when the time input is greater than or equal to the supervisor compare value, both taken as unsigned 64-bit numbers.
- R6: The guest pending output is high exactly when the sum of the time input and the offset, kept to its low 64 bits, is greater than or equal to the guest compare value, compared unsigned.
- R7: A sum of time and offset that passes 2^64 wraps before the comparison, so a large offset can make a small guest time.
- R8: A pending output stays high on every cycle its condition holds and goes low after software writes a compare value above the time operand.
- R9: A read at an address not listed in R2 to R4 returns zero on the read data port, and a write there changes none of the stored values.
- R10: Each pending output reflects the time input and the stored values sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Free-running time count |
| csr_addr_i | input | 12 | Register address for read and write |
| csr_we_i | input | 1 | Write strobe, sampled at the rising edge |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data for the addressed half, combinational |
| stip_o | output | 1 | Supervisor timer pending level |
| vstip_o | output | 1 | Guest timer pending level |

## Verification
Read data follows the address in the same cycle, so the bench samples it one time step after driving the address. A register write lands on the rising edge that samples the strobe, and the pending outputs follow at the next rising edge; a change to the time input shows at the first rising edge after it. The bench drives all inputs on the falling edge and checks the pending outputs on the following falling edge, and for R10 it also checks just before that rising edge that the old level is still present.

// File: rtl/stc_pkg.sv
package stc_pkg;

    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADDR_SCMP_LO  = 12'h14D;
    localparam logic [ADDR_W-1:0] ADDR_SCMP_HI  = 12'h15D;
    localparam logic [ADDR_W-1:0] ADDR_VCMP_LO  = 12'h24D;
    localparam logic [ADDR_W-1:0] ADDR_VCMP_HI  = 12'h25D;
    localparam logic [ADDR_W-1:0] ADDR_DELTA_LO = 12'h64A;
    localparam logic [ADDR_W-1:0] ADDR_DELTA_HI = 12'h65A;

    localparam int unsigned NREG = 3;

    typedef enum logic [1:0] {
        SEL_SCMP  = 2'd0,
        SEL_VCMP  = 2'd1,
        SEL_DELTA = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic     hi;
        reg_sel_e sel;
    } csr_dec_t;

endpackage

// File: rtl/stc_csr_dec.sv
module stc_csr_dec
    import stc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output csr_dec_t          dec_o
);

    always_comb begin
        dec_o = '{hit: 1'b0, hi: 1'b0, sel: SEL_NONE};
        unique case (addr_i)
            ADDR_SCMP_LO:  dec_o = '{hit: 1'b1, hi: 1'b0, sel: SEL_SCMP};
            ADDR_SCMP_HI:  dec_o = '{hit: 1'b1, hi: 1'b1, sel: SEL_SCMP};
            ADDR_VCMP_LO:  dec_o = '{hit: 1'b1, hi: 1'b0, sel: SEL_VCMP};
            ADDR_VCMP_HI:  dec_o = '{hit: 1'b1, hi: 1'b1, sel: SEL_VCMP};
            ADDR_DELTA_LO: dec_o = '{hit: 1'b1, hi: 1'b0, sel: SEL_DELTA};
            ADDR_DELTA_HI: dec_o = '{hit: 1'b1, hi: 1'b1, sel: SEL_DELTA};
            default:       dec_o = '{hit: 1'b0, hi: 1'b0, sel: SEL_NONE};
        endcase
    end

endmodule

// File: rtl/stc_csr_bank.sv
module stc_csr_bank
    import stc_pkg::*;
#(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned CSR_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  csr_dec_t          dec_i,
    input  logic              we_i,
    input  logic [CSR_W-1:0]  wdata_i,
    output logic [CSR_W-1:0]  rdata_o,
    output logic [TIME_W-1:0] scmp_o,
    output logic [TIME_W-1:0] vcmp_o,
    output logic [TIME_W-1:0] delta_o
);

    localparam int unsigned HALF_W = TIME_W / 2;

    typedef struct packed {
        logic [NREG-1:0][TIME_W-1:0] regs;
    } bank_t;

    bank_t                       bank_d, bank_q;
    bank_t                       bank_rst;
    logic [NREG-1:0]             wr_lo, wr_hi;
    logic [NREG-1:0][CSR_W-1:0]  rd_half;
    logic [NREG-1:0]             rd_sel;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam reg_sel_e SEL = reg_sel_e'(g);

        // compare values idle at all ones, the offset idles at zero
        if (SEL == SEL_DELTA) begin : g_zero
            assign bank_rst.regs[g] = '0;
        end else begin : g_ones
            assign bank_rst.regs[g] = '1;
        end

        assign rd_sel[g]  = dec_i.hit && (dec_i.sel == SEL);
        assign wr_lo[g]   = we_i && rd_sel[g] && !dec_i.hi;
        assign wr_hi[g]   = we_i && rd_sel[g] &&  dec_i.hi;
        assign rd_half[g] = dec_i.hi ? bank_q.regs[g][TIME_W-1:HALF_W]
                                     : bank_q.regs[g][HALF_W-1:0];
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_lo[i]) begin
                bank_d.regs[i][HALF_W-1:0] = wdata_i;
            end
            if (wr_hi[i]) begin
                bank_d.regs[i][TIME_W-1:HALF_W] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= bank_rst;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_sel[i]) begin
                rdata_o = rd_half[i];
            end
        end
    end

    assign scmp_o  = bank_q.regs[SEL_SCMP];
    assign vcmp_o  = bank_q.regs[SEL_VCMP];
    assign delta_o = bank_q.regs[SEL_DELTA];

endmodule

// File: rtl/stc_cmp.sv
module stc_cmp #(
    parameter int unsigned TIME_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TIME_W-1:0] time_i,
    input  logic [TIME_W-1:0] offset_i,
    input  logic [TIME_W-1:0] cmp_i,
    output logic              pend_o
);

    typedef struct packed {
        logic pend;
    } cmp_state_t;

    cmp_state_t        state_d, state_q;
    logic [TIME_W-1:0] view_time;

    always_comb begin
        // sum is kept to TIME_W bits, so it wraps modulo 2^TIME_W
        view_time     = time_i + offset_i;
        state_d.pend  = (view_time >= cmp_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_o = state_q.pend;

endmodule

// File: rtl/stc_timer_cmp.sv
module stc_timer_cmp
    import stc_pkg::*;
#(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned CSR_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TIME_W-1:0] time_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic              csr_we_i,
    input  logic [CSR_W-1:0]  csr_wdata_i,
    output logic [CSR_W-1:0]  csr_rdata_o,
    output logic              stip_o,
    output logic              vstip_o
);

    csr_dec_t          dec;
    logic [TIME_W-1:0] scmp_w, vcmp_w, delta_w;

    stc_csr_dec i_dec (
        .addr_i (csr_addr_i),
        .dec_o  (dec)
    );

    stc_csr_bank #(
        .TIME_W (TIME_W),
        .CSR_W  (CSR_W)
    ) i_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .dec_i   (dec),
        .we_i    (csr_we_i),
        .wdata_i (csr_wdata_i),
        .rdata_o (csr_rdata_o),
        .scmp_o  (scmp_w),
        .vcmp_o  (vcmp_w),
        .delta_o (delta_w)
    );

    stc_cmp #(
        .TIME_W (TIME_W)
    ) i_cmp_s (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .time_i   (time_i),
        .offset_i ('0),
        .cmp_i    (scmp_w),
        .pend_o   (stip_o)
    );

    stc_cmp #(
        .TIME_W (TIME_W)
    ) i_cmp_v (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .time_i   (time_i),
        .offset_i (delta_w),
        .cmp_i    (vcmp_w),
        .pend_o   (vstip_o)
    );

endmodule

// File: rtl/stc_timer_cmp_chk.sv
module stc_timer_cmp_chk #(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned CSR_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TIME_W-1:0] time_i,
    input  logic [11:0]       csr_addr_i,
    input  logic              csr_we_i,
    input  logic [CSR_W-1:0]  csr_wdata_i,
    input  logic [CSR_W-1:0]  csr_rdata_o,
    input  logic              stip_o,
    input  logic              vstip_o,
    input  logic [TIME_W-1:0] scmp_i,
    input  logic [TIME_W-1:0] vcmp_i,
    input  logic [TIME_W-1:0] delta_i
);

    logic known_addr;
    logic [TIME_W-1:0] guest_time;

    assign known_addr = (csr_addr_i == 12'h14D) || (csr_addr_i == 12'h15D) ||
                        (csr_addr_i == 12'h24D) || (csr_addr_i == 12'h25D) ||
                        (csr_addr_i == 12'h64A) || (csr_addr_i == 12'h65A);
    assign guest_time = time_i + delta_i;

    // R1
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            reset_quiet_chk: assert (!stip_o && !vstip_o);
        end
    end

    // R5
    stip_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (stip_o == ($past(time_i) >= $past(scmp_i))));

    // R6
    vstip_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (vstip_o == ($past(guest_time) >= $past(vcmp_i))));

    // R9
    unknown_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !known_addr |-> (csr_rdata_o == '0));

    // R9
    unknown_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && !known_addr) |=> ($stable(scmp_i) && $stable(vcmp_i) && $stable(delta_i)));

    // R2
    scmp_lo_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && csr_addr_i == 12'h14D) |=>
        (scmp_i[CSR_W-1:0] == $past(csr_wdata_i) && $stable(scmp_i[TIME_W-1:CSR_W])));

endmodule

bind stc_timer_cmp stc_timer_cmp_chk #(
    .TIME_W (TIME_W),
    .CSR_W  (CSR_W)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .time_i      (time_i),
    .csr_addr_i  (csr_addr_i),
    .csr_we_i    (csr_we_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rdata_o (csr_rdata_o),
    .stip_o      (stip_o),
    .vstip_o     (vstip_o),
    .scmp_i      (scmp_w),
    .vcmp_i      (vcmp_w),
    .delta_i     (delta_w)
);

// File: tb/test_stc_timer_cmp.sv
module test_stc_timer_cmp;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_v = '0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        stip, vstip;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    stc_timer_cmp i_stc_timer_cmp (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .time_i      (time_v),
        .csr_addr_i  (addr),
        .csr_we_i    (we),
        .csr_wdata_i (wdata),
        .csr_rdata_o (rdata),
        .stip_o      (stip),
        .vstip_o     (vstip)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wr64(input logic [11:0] lo, input logic [63:0] v);
        wr(lo, v[31:0]);
        wr(lo + 12'h010, v[63:32]);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd64(input logic [11:0] lo, output logic [63:0] v);
        logic [31:0] l, h;
        rd(lo, l);
        rd(lo + 12'h010, h);
        v = {h, l};
    endtask

    // drive time on the falling edge, check pendings one edge later
    task automatic step_time(input logic [63:0] t);
        time_v = t;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [31:0] w;
        logic [63:0] cmps [6];
        logic [63:0] dels [5];
        cmps = '{64'h0, 64'h1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0000,
                 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE};
        dels = '{64'h0, 64'h5, 64'h0000_0001_0000_0000,
                 64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0000};

        repeat (3) @(negedge clk);
        // R1 during reset and after release
        check("R1 stip in reset", stip, 1'b0);
        check("R1 vstip in reset", vstip, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        rd64(12'h14D, v); check("R1 scmp reset", v, '1);
        rd64(12'h24D, v); check("R1 vcmp reset", v, '1);
        rd64(12'h64A, v); check("R1 delta reset", v, '0);
        check("R1 stip after reset", stip, 1'b0);
        check("R1 vstip after reset", vstip, 1'b0);

        // R2 halves of the supervisor compare value
        wr(12'h14D, 32'h1234_5678);
        rd64(12'h14D, v); check("R2 low write keeps high", v, 64'hFFFF_FFFF_1234_5678);
        wr(12'h15D, 32'h9ABC_DEF0);
        rd64(12'h14D, v); check("R2 high write keeps low", v, 64'h9ABC_DEF0_1234_5678);
        // R3 halves of the guest compare value
        wr(12'h25D, 32'h0BAD_F00D);
        rd64(12'h24D, v); check("R3 high write keeps low", v, 64'h0BAD_F00D_FFFF_FFFF);
        wr(12'h24D, 32'hCAFE_0001);
        rd64(12'h24D, v); check("R3 low write", v, 64'h0BAD_F00D_CAFE_0001);
        // R4 offset halves
        wr64(12'h64A, 64'h0102_0304_0506_0708);
        rd64(12'h64A, v); check("R4 offset", v, 64'h0102_0304_0506_0708);
        rd64(12'h14D, v); check("R4 scmp untouched", v, 64'h9ABC_DEF0_1234_5678);

        // R9 unknown addresses
        foreach (cmps[k]) begin
            logic [11:0] bad;
            bad = (k == 0) ? 12'h14C : (k == 1) ? 12'h14E : (k == 2) ? 12'h000 :
                  (k == 3) ? 12'hFFF : (k == 4) ? 12'h35D : 12'h64B;
            wr(bad, 32'hDEAD_BEEF);
            rd(bad, w); check("R9 unknown read zero", w, 32'h0);
        end
        rd64(12'h14D, v); check("R9 scmp unchanged", v, 64'h9ABC_DEF0_1234_5678);
        rd64(12'h24D, v); check("R9 vcmp unchanged", v, 64'h0BAD_F00D_CAFE_0001);
        rd64(12'h64A, v); check("R9 offset unchanged", v, 64'h0102_0304_0506_0708);

        // R5 sweep around each supervisor compare boundary
        wr64(12'h64A, 64'h0);
        wr64(12'h24D, '1);
        foreach (cmps[k]) begin
            wr64(12'h14D, cmps[k]);
            for (int d = -2; d <= 2; d++) begin
                logic [63:0] t;
                t = cmps[k] + 64'(signed'(d));
                step_time(t);
                check("R5 stip sweep", stip, t >= cmps[k]);
                check("R5 vstip idle", vstip, t == '1);
            end
        end

        // R6 and R7 sweep over offsets, including wrap-around sums
        wr64(12'h14D, '1);
        foreach (dels[j]) begin
            wr64(12'h64A, dels[j]);
            foreach (cmps[k]) begin
                wr64(12'h24D, cmps[k]);
                for (int d = -2; d <= 2; d++) begin
                    logic [63:0] t, g;
                    t = cmps[k] - dels[j] + 64'(signed'(d));
                    g = t + dels[j];
                    step_time(t);
                    check((t > ~dels[j]) ? "R7 wrapped sum" : "R6 vstip sweep", vstip, g >= cmps[k]);
                end
            end
        end
        // R7 explicit: large offset makes small guest time
        wr64(12'h64A, 64'hFFFF_FFFF_FFFF_FFF0);
        wr64(12'h24D, 64'h100);
        step_time(64'h20);
        check("R7 wrap below compare", vstip, 1'b0);
        step_time(64'h110);
        check("R7 wrap reaches compare", vstip, 1'b1);

        // R8 level hold then clear by raising the compare value
        wr64(12'h64A, 64'h0);
        wr64(12'h14D, 64'h1000);
        wr64(12'h24D, 64'h1000);
        step_time(64'h2000);
        for (int c = 0; c < 4; c++) begin
            check("R8 stip held", stip, 1'b1);
            check("R8 vstip held", vstip, 1'b1);
            @(negedge clk);
        end
        wr(12'h15D, 32'h1);
        @(negedge clk);
        check("R8 stip cleared", stip, 1'b0);
        check("R8 vstip still held", vstip, 1'b1);
        wr(12'h25D, 32'h1);
        @(negedge clk);
        check("R8 vstip cleared", vstip, 1'b0);

        // R10 one cycle latency on a time change
        wr64(12'h14D, 64'h5000);
        time_v = 64'h5000;
        #1;
        check("R10 stip before edge", stip, 1'b0);
        @(negedge clk);
        check("R10 stip after edge", stip, 1'b1);
        // R10 latency on a compare write: register lands, pending one edge later
        wr(12'h14D, 32'h6000);
        check("R10 stip old after write", stip, 1'b1);
        @(negedge clk);
        check("R10 stip new after write", stip, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule